// File: doc/BRIEF.md
# Masked Packed Integer-to-Float Converter

This block turns a vector of signed 32-bit integers into IEEE-754 single-precision values, with every lane converted in parallel. A 512-bit register is viewed as 4, 8 or 16 lanes (128, 256 or 512 bits). A write mask chooses which lanes take the converted value. Lanes left out by the mask either keep the previous destination contents (merge) or are cleared (zero).

A memory-sourced operation may broadcast one 32-bit element to every lane. A full-width register-sourced operation may carry its own rounding mode in place of the global one. A legacy mode works on 128 bits, ignores masking and broadcast, and leaves the upper destination bits untouched. A malformed reserved operand field raises an encoding fault and blocks the write. The block samples its operands on a valid strobe and presents a registered result one cycle later, together with an inexact flag.

Top module: `vec_i2f_unit`

## Requirements
- R1: An integer with magnitude up to 2^24 converts exactly. Zero gives 0x00000000, and negative inputs take sign bit 1 with their magnitude. 0x80000000 gives 0xCF000000, 1 gives 0x3F800000 and -1 gives 0xBF800000.
- R2: Larger magnitudes are rounded to a 24-bit significand. The rounding-mode code is 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. A round-up that overflows the significand raises the exponent by one; for example 0x7FFFFFFF becomes 0x4F000000 under nearest-even and 0x4EFFFFFF under toward-zero.
- R3: A lane inside the vector length takes its converted value when its bit in `msk_bits` is 1 or when `msk_en` is 0.
- R4: With `msk_en`=1 and `msk_zero`=0, a lane inside the vector length whose mask bit is 0 keeps its `dst_prev` value.
- R5: With `msk_en`=1 and `msk_zero`=1, a lane inside the vector length whose mask bit is 0 becomes zero.
- R6: When `src_mem`=1 and `bcast_rc`=1, every converted lane uses `src_vec[31:0]`. A register source (`src_mem`=0) never broadcasts.
- R7: `rc_inline` sets the rounding mode only for a non-legacy operation at 512 bits with `src_mem`=0 and `bcast_rc`=1. In every other case `rc_default` sets it.
- R8: `vl_sel` selects the vector length: 00 is 4 lanes, 01 is 8 lanes, and 10 or 11 is 16 lanes. Outside legacy mode, lanes beyond the vector length read as zero.
- R9: With `legacy_mode`=1, the operation covers lanes 0 to 3 whatever `vl_sel` says. The mask, broadcast and inline rounding are ignored, and lanes 4 and up keep their `dst_prev` value.
- R10: When `opnd_spec` is not 4'b1111, `enc_fault` is 1, the result equals `dst_prev` in full and `prec_flag` is 0. Otherwise `enc_fault` is 0.
- R11: `prec_flag` is 1 exactly when some converted lane's result differs from its integer value. Lanes that are masked off or beyond the vector length never set it.
- R12: `out_valid` follows `in_valid` one cycle later. In a cycle after `in_valid` was 0, `res_vec`, `prec_flag` and `enc_fault` keep their previous values.
- R13: After reset, `out_valid`, `res_vec`, `prec_flag` and `enc_fault` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid; sampled at the clock edge |
| vl_sel | input | 2 | Vector length select |
| legacy_mode | input | 1 | Legacy 128-bit operation |
| src_vec | input | NL*32 | Source integers, lane j at [32j+31:32j] |
| src_mem | input | 1 | Source came from memory |
| bcast_rc | input | 1 | Broadcast (memory source) or inline rounding enable (register source) |
| dst_prev | input | NL*32 | Previous destination contents |
| msk_en | input | 1 | Write masking enabled |
| msk_zero | input | 1 | 1 = zero masked-off lanes, 0 = merge |
| msk_bits | input | NL | Per-lane write mask |
| rc_inline | input | 2 | Inline rounding mode |
| rc_default | input | 2 | Global rounding mode |
| opnd_spec | input | 4 | Reserved operand field, must be 4'b1111 |
| out_valid | output | 1 | Result valid |
| res_vec | output | NL*32 | Full-width result |
| prec_flag | output | 1 | Inexact result in some converted lane |
| enc_fault | output | 1 | Invalid encoding; write suppressed |

## Verification
The bench uses the default 16 lanes, because the inline rounding path and the upper-zeroing boundaries at 128 and 256 bits appear only with the full 512-bit register. At that width each operation drives 16 independent converters. A few hundred operations therefore cover several thousand conversions under every rounding mode. They include exact ties, all-ones significands that carry into the exponent, and the most negative integer. Mask patterns, vector lengths, the legacy and broadcast controls and every faulting value of the reserved field are combined around the same arithmetic reference.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int LANE_W = 32;
  localparam int SIG_W  = 24;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rm_e;

  function automatic logic [4:0] msb_index(input logic [LANE_W-1:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < LANE_W; i++) begin
      if (v[i]) r = i[4:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/i2f_lane_cvt.sv
module i2f_lane_cvt
  import i2f_pkg::*;
(
  input  logic [LANE_W-1:0] ival,
  input  rm_e               rm,
  output logic [LANE_W-1:0] fval,
  output logic              inexact
);
  logic              neg;
  logic [LANE_W-1:0] mag;
  logic [LANE_W-1:0] norm;
  logic [4:0]        lead;
  logic              guard, sticky, lsb, up;
  logic [SIG_W:0]    sig;
  logic [7:0]        expo;

  always_comb begin
    neg     = ival[LANE_W-1];
    mag     = neg ? (~ival + 32'd1) : ival;
    lead    = msb_index(mag);
    norm    = mag << (5'd31 - lead);
    lsb     = norm[8];
    guard   = norm[7];
    sticky  = |norm[6:0];
    inexact = guard | sticky;
    case (rm)
      RM_NEAR: up = guard & (sticky | lsb);
      RM_DOWN: up = neg & inexact;
      RM_UP:   up = ~neg & inexact;
      default: up = 1'b0;
    endcase
    sig  = {1'b0, norm[31:8]} + {{SIG_W{1'b0}}, up};
    expo = 8'd127 + {3'd0, lead} + {7'd0, sig[SIG_W]};
    if (mag == '0) fval = '0;
    else           fval = {neg, expo, sig[SIG_W] ? 23'd0 : sig[22:0]};
  end
endmodule

// File: rtl/i2f_ctrl.sv
module i2f_ctrl
  import i2f_pkg::*;
#(
  parameter int NL = 16
) (
  input  logic [1:0]    vl_sel,
  input  logic          legacy_mode,
  input  logic          src_mem,
  input  logic          bcast_rc,
  input  logic          msk_en,
  input  logic [NL-1:0] msk_bits,
  input  logic [1:0]    rc_inline,
  input  logic [1:0]    rc_default,
  input  logic [3:0]    opnd_spec,
  output rm_e           rm,
  output logic          use_bcast,
  output logic          fault,
  output logic [NL-1:0] lane_in_vl,
  output logic [NL-1:0] lane_act
);
  logic full_w;

  assign full_w    = vl_sel[1] & ~legacy_mode;
  assign rm        = rm_e'((full_w & ~src_mem & bcast_rc) ? rc_inline : rc_default);
  assign use_bcast = src_mem & bcast_rc & ~legacy_mode;
  assign fault     = (opnd_spec != 4'b1111);

  for (genvar j = 0; j < NL; j++) begin : g_lane
    if (j < 4) begin : g_low
      assign lane_in_vl[j] = 1'b1;
    end else if (j < 8) begin : g_mid
      assign lane_in_vl[j] = ~legacy_mode & (vl_sel != 2'b00);
    end else begin : g_high
      assign lane_in_vl[j] = ~legacy_mode & vl_sel[1];
    end
    assign lane_act[j] = lane_in_vl[j] & (legacy_mode | ~msk_en | msk_bits[j]);
  end
endmodule

// File: rtl/i2f_lane_out.sv
module i2f_lane_out
  import i2f_pkg::*;
(
  input  logic [LANE_W-1:0] cvt,
  input  logic [LANE_W-1:0] old,
  input  logic              cvt_inx,
  input  logic              act,
  input  logic              in_vl,
  input  logic              zmask,
  input  logic              keep_up,
  input  logic              fault,
  output logic [LANE_W-1:0] lane,
  output logic              inx
);
  always_comb begin
    inx = 1'b0;
    if (fault) begin
      lane = old;
    end else if (act) begin
      lane = cvt;
      inx  = cvt_inx;
    end else if (in_vl) begin
      lane = zmask ? '0 : old;
    end else begin
      lane = keep_up ? old : '0;
    end
  end
endmodule

// File: rtl/vec_i2f_unit.sv
module vec_i2f_unit
  import i2f_pkg::*;
#(
  parameter int NL = 16,
  localparam int VW = NL * LANE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    vl_sel,
  input  logic          legacy_mode,
  input  logic [VW-1:0] src_vec,
  input  logic          src_mem,
  input  logic          bcast_rc,
  input  logic [VW-1:0] dst_prev,
  input  logic          msk_en,
  input  logic          msk_zero,
  input  logic [NL-1:0] msk_bits,
  input  logic [1:0]    rc_inline,
  input  logic [1:0]    rc_default,
  input  logic [3:0]    opnd_spec,
  output logic          out_valid,
  output logic [VW-1:0] res_vec,
  output logic          prec_flag,
  output logic          enc_fault
);
  rm_e                        rm;
  logic                       use_bcast, fault;
  logic [NL-1:0]              lane_in_vl, lane_act, lane_inx;
  logic [NL-1:0][LANE_W-1:0]  lane_res;

  i2f_ctrl #(.NL(NL)) u_ctrl (
    .vl_sel(vl_sel), .legacy_mode(legacy_mode), .src_mem(src_mem),
    .bcast_rc(bcast_rc), .msk_en(msk_en), .msk_bits(msk_bits),
    .rc_inline(rc_inline), .rc_default(rc_default), .opnd_spec(opnd_spec),
    .rm(rm), .use_bcast(use_bcast), .fault(fault),
    .lane_in_vl(lane_in_vl), .lane_act(lane_act)
  );

  for (genvar j = 0; j < NL; j++) begin : g_lane
    logic [LANE_W-1:0] l_src, l_cvt;
    logic              l_cinx;

    assign l_src = use_bcast ? src_vec[LANE_W-1:0] : src_vec[j*LANE_W +: LANE_W];

    i2f_lane_cvt u_cvt (.ival(l_src), .rm(rm), .fval(l_cvt), .inexact(l_cinx));

    i2f_lane_out u_out (
      .cvt(l_cvt), .old(dst_prev[j*LANE_W +: LANE_W]), .cvt_inx(l_cinx),
      .act(lane_act[j]), .in_vl(lane_in_vl[j]), .zmask(msk_zero),
      .keep_up(legacy_mode), .fault(fault),
      .lane(lane_res[j]), .inx(lane_inx[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_vec   <= '0;
      prec_flag <= 1'b0;
      enc_fault <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_vec   <= lane_res;
        prec_flag <= |lane_inx;
        enc_fault <= fault;
      end
    end
  end
endmodule

// File: rtl/vec_i2f_unit_chk.sv
module vec_i2f_unit_chk #(
  parameter int NL = 16,
  localparam int VW = NL * 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [1:0]    vl_sel,
  input logic          legacy_mode,
  input logic [VW-1:0] dst_prev,
  input logic          msk_en,
  input logic          msk_zero,
  input logic [NL-1:0] msk_bits,
  input logic [3:0]    opnd_spec,
  input logic          out_valid,
  input logic [VW-1:0] res_vec,
  input logic          prec_flag,
  input logic          enc_fault
);
  logic ok_enc;
  assign ok_enc = (opnd_spec == 4'b1111);

  p_latency_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(res_vec) && $stable(prec_flag) && $stable(enc_fault)));

  p_fault_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ok_enc) |=> (enc_fault && !prec_flag && res_vec == $past(dst_prev)));

  p_merge_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ok_enc && !legacy_mode && vl_sel[1] && msk_en && !msk_zero && msk_bits == '0)
      |=> (res_vec == $past(dst_prev) && !prec_flag));

  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ok_enc && !legacy_mode && msk_en && msk_zero && msk_bits == '0)
      |=> (res_vec == '0 && !prec_flag && !enc_fault));

  if (NL > 4) begin : g_upper
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && ok_enc && !legacy_mode && vl_sel == 2'b00) |=> (res_vec[VW-1:128] == '0));

    p_legacy_keep_r9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && ok_enc && legacy_mode) |=> (res_vec[VW-1:128] == $past(dst_prev[VW-1:128])));
  end
endmodule

bind vec_i2f_unit vec_i2f_unit_chk #(.NL(NL)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .vl_sel(vl_sel),
  .legacy_mode(legacy_mode), .dst_prev(dst_prev), .msk_en(msk_en),
  .msk_zero(msk_zero), .msk_bits(msk_bits), .opnd_spec(opnd_spec),
  .out_valid(out_valid), .res_vec(res_vec), .prec_flag(prec_flag),
  .enc_fault(enc_fault)
);

// File: tb/vec_i2f_unit_bench.sv
`timescale 1ns/1ps
module vec_i2f_unit_bench;
  localparam int NL = 16;
  localparam int VW = NL * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    vl_sel;
  logic          legacy_mode, src_mem, bcast_rc, msk_en, msk_zero;
  logic [VW-1:0] src_vec, dst_prev;
  logic [NL-1:0] msk_bits;
  logic [1:0]    rc_inline, rc_default;
  logic [3:0]    opnd_spec;
  logic          out_valid, prec_flag, enc_fault;
  logic [VW-1:0] res_vec;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] rs = 32'h2468_ACE1;

  always #10 clk = ~clk;

  vec_i2f_unit #(.NL(NL)) u_vec_i2f_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vl_sel(vl_sel),
    .legacy_mode(legacy_mode), .src_vec(src_vec), .src_mem(src_mem),
    .bcast_rc(bcast_rc), .dst_prev(dst_prev), .msk_en(msk_en),
    .msk_zero(msk_zero), .msk_bits(msk_bits), .rc_inline(rc_inline),
    .rc_default(rc_default), .opnd_spec(opnd_spec), .out_valid(out_valid),
    .res_vec(res_vec), .prec_flag(prec_flag), .enc_fault(enc_fault)
  );

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int j = 0; j < NL; j++) v[j*32 +: 32] = rnd();
    return v;
  endfunction

  // arithmetic reference: {inexact, float bits}
  function automatic logic [32:0] ref_conv(input logic [31:0] x, input logic [1:0] rm);
    longint m, q, rem, half;
    int p, sh;
    logic s, up, inx;
    logic [7:0] e;
    s = x[31];
    m = s ? -longint'($signed(x)) : longint'(x);
    if (m == 0) return 33'd0;
    p = 0;
    for (int k = 0; k < 32; k++) if (m >= (longint'(1) << k)) p = k;
    inx = 1'b0;
    if (p <= 23) begin
      q = m << (23 - p);
    end else begin
      sh   = p - 23;
      q    = m >> sh;
      rem  = m - (q << sh);
      half = longint'(1) << (sh - 1);
      inx  = (rem != 0);
      case (rm)
        2'b00:   up = (rem > half) || ((rem == half) && q[0]);
        2'b01:   up = s && inx;
        2'b10:   up = !s && inx;
        default: up = 1'b0;
      endcase
      if (up) q = q + 1;
    end
    e = 8'(127 + p);
    if (q == (longint'(1) << 24)) begin
      q = longint'(1) << 23;
      e = e + 8'd1;
    end
    return {inx, s, e, q[22:0]};
  endfunction

  task automatic model(output logic [VW-1:0] er, output logic ei, output logic eb);
    int nl;
    logic fullw, bc, act;
    logic [1:0] rmx;
    logic [32:0] r;
    nl    = legacy_mode ? 4 : (vl_sel == 2'b00 ? 4 : (vl_sel == 2'b01 ? 8 : 16));
    fullw = !legacy_mode && vl_sel[1];
    rmx   = (fullw && !src_mem && bcast_rc) ? rc_inline : rc_default;
    bc    = !legacy_mode && src_mem && bcast_rc;
    eb    = (opnd_spec != 4'hF);
    ei    = 1'b0;
    for (int j = 0; j < NL; j++) begin
      if (eb) er[j*32 +: 32] = dst_prev[j*32 +: 32];
      else if (j >= nl) er[j*32 +: 32] = legacy_mode ? dst_prev[j*32 +: 32] : 32'd0;
      else begin
        act = legacy_mode || !msk_en || msk_bits[j];
        if (act) begin
          r = ref_conv(bc ? src_vec[31:0] : src_vec[j*32 +: 32], rmx);
          er[j*32 +: 32] = r[31:0];
          ei = ei | r[32];
        end else begin
          er[j*32 +: 32] = msk_zero ? 32'd0 : dst_prev[j*32 +: 32];
        end
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic defaults();
    vl_sel = 2'b10; legacy_mode = 1'b0; src_mem = 1'b0; bcast_rc = 1'b0;
    msk_en = 1'b0; msk_zero = 1'b0; msk_bits = '0; rc_inline = 2'b00;
    rc_default = 2'b00; opnd_spec = 4'hF;
    src_vec = rnd_vec(); dst_prev = rnd_vec();
  endtask

  // one operation: inputs already set at a falling edge
  task automatic run(input string tag);
    logic [VW-1:0] er;
    logic ei, eb;
    model(er, ei, eb);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, "valid", VW'(out_valid), VW'(1));
    chk(tag, "result", res_vec, er);
    chk(tag, "inexact", VW'(prec_flag), VW'(ei));
    chk(tag, "fault", VW'(enc_fault), VW'(eb));
  endtask

  function automatic logic [31:0] exact_val(input int j);
    case (j)
      0: return 32'h0000_0000;   1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;   3: return 32'h0000_0002;
      4: return 32'h00FF_FFFF;   5: return 32'h0100_0000;
      6: return 32'hFF00_0000;   7: return 32'h8000_0000;
      8: return 32'h0001_2345;   9: return 32'hFFFF_FFF9;
      10: return 32'h4000_0000;  11: return 32'h0080_0000;
      12: return 32'h0000_0007;  13: return 32'h7FFF_FF80;
      14: return 32'h1000_0000;  default: return 32'hC000_0000;
    endcase
  endfunction

  function automatic logic [31:0] sweep_val(input int t, input int j);
    logic [31:0] r, v;
    logic [23:0] m;
    int sh;
    r = rnd();
    case ((t + j) % 5)
      0: v = r;
      1: v = r >> r[4:0];
      2: begin
        m  = {1'b1, r[22:0]};
        sh = 1 + int'(r[28:24]) % 7;
        v  = ({8'd0, m} << sh) | (32'd1 << (sh - 1));
        if (r[31]) v = ~v + 32'd1;
      end
      3: begin
        v = 32'hFFFF_FFFF >> (1 + int'(r[2:0]));
        if (r[31]) v = ~v + 32'd1;
      end
      default: begin
        v = {8'd0, r[23:0]};
        if (r[31]) v = ~v + 32'd1;
      end
    endcase
    return v;
  endfunction

  initial begin
    defaults();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    chk("R13", "valid", VW'(out_valid), '0);
    chk("R13", "result", res_vec, '0);
    chk("R13", "inexact", VW'(prec_flag), '0);
    chk("R13", "fault", VW'(enc_fault), '0);

    // R1 exact values under every rounding mode
    for (int rm = 0; rm < 4; rm++) begin
      defaults();
      rc_default = 2'(rm);
      for (int j = 0; j < NL; j++) src_vec[j*32 +: 32] = exact_val(j);
      run("R1");
      chk("R1", "zero lane", VW'(res_vec[31:0]), VW'(32'h0000_0000));
      chk("R1", "one lane", VW'(res_vec[63:32]), VW'(32'h3F80_0000));
      chk("R1", "minus one lane", VW'(res_vec[95:64]), VW'(32'hBF80_0000));
      chk("R1", "most negative lane", VW'(res_vec[255:224]), VW'(32'hCF00_0000));
    end

    // R2 carry into exponent, direct constants
    defaults();
    src_vec[31:0] = 32'h7FFF_FFFF;
    run("R2");
    chk("R2", "nearest carry", VW'(res_vec[31:0]), VW'(32'h4F00_0000));
    rc_default = 2'b11;
    run("R2");
    chk("R2", "toward zero", VW'(res_vec[31:0]), VW'(32'h4EFF_FFFF));

    // R2 rounding sweep
    for (int rm = 0; rm < 4; rm++) begin
      for (int t = 0; t < 64; t++) begin
        defaults();
        rc_default = 2'(rm);
        for (int j = 0; j < NL; j++) src_vec[j*32 +: 32] = sweep_val(t, j);
        run("R2");
      end
    end

    // R3 R4 R5 masking
    for (int t = 0; t < 24; t++) begin
      for (int z = 0; z < 2; z++) begin
        defaults();
        msk_en   = 1'b1;
        msk_zero = z[0];
        case (t)
          0: msk_bits = '0;
          1: msk_bits = '1;
          2: msk_bits = 16'hAAAA;
          3: msk_bits = 16'h5555;
          default: msk_bits = (t < 20) ? NL'(1) << (t - 4) : NL'(rnd());
        endcase
        for (int j = 0; j < NL; j++) src_vec[j*32 +: 32] = sweep_val(t, j);
        run(z == 0 ? "R4" : "R5");
      end
    end
    defaults();
    msk_en = 1'b0; msk_bits = '0;
    run("R3");
    defaults();
    msk_en = 1'b1; msk_bits = '1; msk_zero = 1'b1;
    run("R3");

    // R11 inexact counts only converted lanes
    for (int k = 0; k < 2; k++) begin
      defaults();
      for (int j = 0; j < NL; j++) src_vec[j*32 +: 32] = exact_val(j);
      src_vec[31:0] = 32'h7FFF_FFFF;
      msk_en = 1'b1; msk_bits = k[0] ? '1 : ~NL'(1);
      run("R11");
      chk("R11", "flag", VW'(prec_flag), VW'(k));
    end
    defaults();
    for (int j = 0; j < NL; j++) src_vec[j*32 +: 32] = exact_val(j);
    src_vec[511:480] = 32'h7FFF_FFFF;
    vl_sel = 2'b01;
    run("R11");
    chk("R11", "flag beyond length", VW'(prec_flag), '0);

    // R6 broadcast
    for (int v = 0; v < 4; v++) begin
      defaults();
      vl_sel = 2'(v); src_mem = 1'b1; bcast_rc = 1'b1;
      msk_en = 1'b1; msk_bits = 16'h3C5F;
      run("R6");
    end
    defaults();
    src_mem = 1'b0; bcast_rc = 1'b1; vl_sel = 2'b01;
    run("R6");
    defaults();
    src_mem = 1'b1; bcast_rc = 1'b0;
    run("R6");

    // R7 rounding source selection
    for (int c = 0; c < 6; c++) begin
      defaults();
      for (int j = 0; j < NL; j++) src_vec[j*32 +: 32] = 32'h0100_0003 + 32'(j * 2);
      rc_default = 2'b11; rc_inline = 2'b10; bcast_rc = 1'b1;
      case (c)
        0: vl_sel = 2'b10;
        1: vl_sel = 2'b11;
        2: vl_sel = 2'b01;
        3: vl_sel = 2'b00;
        4: src_mem = 1'b1;
        default: begin vl_sel = 2'b10; bcast_rc = 1'b0; end
      endcase
      run("R7");
    end

    // R8 vector length and upper zeroing
    for (int v = 0; v < 4; v++) begin
      for (int m = 0; m < 2; m++) begin
        defaults();
        dst_prev = '1; vl_sel = 2'(v);
        msk_en = m[0]; msk_bits = 16'h0F0F;
        run("R8");
      end
    end

    // R9 legacy mode
    for (int v = 0; v < 4; v++) begin
      defaults();
      legacy_mode = 1'b1; vl_sel = 2'(v); msk_en = 1'b1; msk_bits = '0;
      msk_zero = v[0]; bcast_rc = 1'b1; src_mem = v[1];
      rc_inline = 2'b10; rc_default = 2'b11;
      src_vec[31:0] = 32'h0100_0003;
      run("R9");
    end

    // R10 every faulting reserved value
    for (int s = 0; s < 15; s++) begin
      defaults();
      opnd_spec = 4'(s); msk_en = 1'b1; msk_zero = 1'b1; msk_bits = 16'h00FF;
      src_vec[31:0] = 32'h7FFF_FFFF;
      run("R10");
    end

    // R12 latency and hold while idle
    defaults();
    src_vec[31:0] = 32'h7FFF_FFFF;
    run("R12");
    begin
      logic [VW-1:0] held;
      logic hf;
      held = res_vec;
      hf = prec_flag;
      defaults();
      opnd_spec = 4'h0;
      @(posedge clk);
      @(negedge clk);
      chk("R12", "idle valid", VW'(out_valid), '0);
      chk("R12", "idle hold", res_vec, held);
      chk("R12", "idle flag hold", VW'(prec_flag), VW'(hf));
      chk("R12", "idle fault hold", VW'(enc_fault), '0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule